// File: doc/BRIEF.md
# SD Host Transfer-Mode Gate and Buffer Port

This block is a slice of an SD host controller's register file. It holds the 32-bit word that combines the 16-bit transfer-mode field (lower half) with the 16-bit command field (upper half). It also holds the data-transfer inhibit flag and the two buffer-enable flags that software sees in the present-state word. Behind the buffer data port sits a 512-byte block buffer. A byte pointer walks that buffer and can never run past its end.

Software reaches the block over a simple word-addressed bus that carries per-byte enables. The register behaviour follows a fixed set of rules. While a data transfer is in flight, writes to the transfer-mode field are dropped. The DMA-enable bit is cleared whenever the capability input reports no single-operation DMA support. Each byte moved through the port advances the pointer by one, and block completions are counted down until the transfer ends. Bytes that would land beyond the buffer are dropped, and a sticky error flag is raised in their place. Card signalling, response handling and DMA engines are not part of this block.

Top module: `sdhx_xfer_gate`

## Requirements
- R1: After reset, transfer mode, command, block size, block count, present state, both ready outputs and the error flag are all zero.
- R2: While the data inhibit flag (present-state bit 1) is 1, writes to the transfer-mode half of word 3 leave it unchanged, and the command half of the same word still takes the written bytes. When the flag is 0, transfer-mode writes are stored.
- R3: Word writes honour byte enables. Enable 0 selects transfer-mode bits 7:0, enable 1 selects transfer-mode bits 15:8, enable 2 selects command bits 7:0 (data bits 23:16) and enable 3 selects command bits 15:8 (data bits 31:24).
- R4: When `cap_sdma` is 0, a stored transfer-mode low byte always has bit 0 (DMA enable) cleared. When `cap_sdma` is 1, bit 0 is kept as written.
- R5: A write with byte enable 3 to word 3 issues a data command if the resulting command bit 5 is 1 and the inhibit flag is 0. From the next cycle, inhibit is 1, and exactly one enable is set: read enable (present-state bit 11, `buf_rd_rdy`) if transfer-mode bit 4 is 1, or otherwise write enable (bit 10, `buf_wr_rdy`). While inhibit is 1, no further command is issued.
- R6: Accesses to the data port (word 8) move 1, 2 or 4 bytes for byte-enable patterns 0001, 0011 or 1111. Byte i of an access sits on data bits 8i+7:8i (little-endian). Any other pattern has no effect. A write only takes effect while write enable is set, and a read only takes effect while read enable is set. A read without read enable returns zero.
- R7: Each byte moved advances the pointer by one. When the pointer reaches the block size (word 1 bits 11:0), the pointer returns to zero and the block count (word 1 bits 31:16) drops by one. Bytes of the same access that lie beyond the block end are dropped, and on a read they return zero.
- R8: When a block completes with a block count of 1, the inhibit flag and both enables clear.
- R9: The pointer never exceeds 512. A byte whose index would be 512 or more is dropped (or reads as zero) and sets the sticky error output `buf_err`. Earlier buffer contents are not overwritten.
- R10: Writing word 11 with byte enable 3 and data bit 26 set clears the inhibit flag, both enables, the pointer and the error flag.
- R11: Reads return the present state on word 9 and the stored values on words 1 and 3, within the same cycle as the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_word | input | 6 | Word address (byte offset divided by 4) |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| cap_sdma | input | 1 | Capability: single-operation DMA supported |
| prs_state | output | 32 | Present-state word |
| xfer_mode | output | 16 | Stored transfer mode |
| cmd_val | output | 16 | Stored command |
| buf_rd_rdy | output | 1 | Buffer read enable |
| buf_wr_rdy | output | 1 | Buffer write enable |
| buf_err | output | 1 | Sticky buffer-bound error |

## Verification
A register write or a port access takes effect at the first rising edge after the cycle in which its strobe is asserted. Outputs and readback therefore change one edge later. Read data and the present state are combinational, so a read returns the value held before that same edge, and a data-port read advances the pointer at that edge. The bench drives on the falling edge. It samples read data two nanoseconds later, before the rising edge, and it checks register outputs on the falling edge that follows each write.

// File: rtl/sdhx_pkg.sv
package sdhx_pkg;
   localparam logic [5:0] W_BLK  = 6'd1;
   localparam logic [5:0] W_XCMD = 6'd3;
   localparam logic [5:0] W_PORT = 6'd8;
   localparam logic [5:0] W_PRS  = 6'd9;
   localparam logic [5:0] W_RST  = 6'd11;

   localparam int unsigned XM_DMA     = 0;
   localparam int unsigned XM_DIR_RD  = 4;
   localparam int unsigned CMD_DATA   = 5;
   localparam int unsigned PS_INH     = 1;
   localparam int unsigned PS_WR_EN   = 10;
   localparam int unsigned PS_RD_EN   = 11;
   localparam int unsigned RST_DAT    = 26;

   function automatic logic [2:0] port_bytes(input logic [3:0] be);
      case (be)
         4'b0001: return 3'd1;
         4'b0011: return 3'd2;
         4'b1111: return 3'd4;
         default: return 3'd0;
      endcase
   endfunction
endpackage

// File: rtl/sdhx_mode_regs.sv
module sdhx_mode_regs
   import sdhx_pkg::*;
#(
   parameter int unsigned BS_W = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic            blk_wr_i,
   input  logic [31:0]     wdata_i,
   input  logic [3:0]      be_i,
   input  logic            inhibit_i,
   input  logic            cap_sdma_i,
   output logic [15:0]     xfer_o,
   output logic [15:0]     cmd_o,
   output logic [BS_W-1:0] blk_size_o,
   output logic            issue_o,
   output logic            issue_rd_o
);
   if (BS_W < 9 || BS_W > 16) begin : g_bad_bsw
      $error("BS_W must lie in 9..16");
   end

   logic [15:0]     xfer_q, cmd_q, xfer_nx, cmd_nx;
   logic [BS_W-1:0] blk_q, blk_nx;

   always_comb begin
      xfer_nx = xfer_q;
      cmd_nx  = cmd_q;
      if (wr_i && !inhibit_i) begin
         if (be_i[0]) xfer_nx[7:0]  = wdata_i[7:0];
         if (be_i[1]) xfer_nx[15:8] = wdata_i[15:8];
         if (be_i[0] && !cap_sdma_i) xfer_nx[XM_DMA] = 1'b0;
      end
      if (wr_i) begin
         if (be_i[2]) cmd_nx[7:0]  = wdata_i[23:16];
         if (be_i[3]) cmd_nx[15:8] = wdata_i[31:24];
      end
   end

   always_comb begin
      blk_nx = blk_q;
      if (blk_wr_i) begin
         if (be_i[0]) blk_nx[7:0]      = wdata_i[7:0];
         if (be_i[1]) blk_nx[BS_W-1:8] = wdata_i[BS_W-1:8];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         xfer_q <= '0;
         cmd_q  <= '0;
         blk_q  <= '0;
      end else begin
         xfer_q <= xfer_nx;
         cmd_q  <= cmd_nx;
         blk_q  <= blk_nx;
      end
   end

   assign issue_o    = wr_i && be_i[3] && cmd_nx[CMD_DATA] && !inhibit_i;
   assign issue_rd_o = xfer_nx[XM_DIR_RD];
   assign xfer_o     = xfer_q;
   assign cmd_o      = cmd_q;
   assign blk_size_o = blk_q;

   p_hold_xfer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && inhibit_i && (be_i[1:0] != 2'b00)) |=> $stable(xfer_q));
   p_cmd_hi_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && be_i[3]) |=> (cmd_q[15:8] == $past(wdata_i[31:24])));
   p_dma_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && be_i[0] && !inhibit_i && !cap_sdma_i) |=> !xfer_q[XM_DMA]);
endmodule

// File: rtl/sdhx_xfer_ctl.sv
module sdhx_xfer_ctl #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_i,
   input  logic             issue_rd_i,
   input  logic             dat_rst_i,
   input  logic             blk_done_i,
   input  logic             cnt_wr_i,
   input  logic [CNT_W-1:0] wd_hi_i,
   input  logic [1:0]       be_hi_i,
   output logic             inhibit_o,
   output logic             rd_en_o,
   output logic             wr_en_o,
   output logic [CNT_W-1:0] blk_cnt_o
);
   if (CNT_W != 16) begin : g_bad_cnt
      $error("CNT_W must be 16 to fill the upper half-word");
   end

   logic             inh_q, rd_q, wr_q;
   logic [CNT_W-1:0] cnt_q;
   logic             last_blk;

   assign last_blk = blk_done_i && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inh_q <= 1'b0;
         rd_q  <= 1'b0;
         wr_q  <= 1'b0;
      end else if (dat_rst_i) begin
         inh_q <= 1'b0;
         rd_q  <= 1'b0;
         wr_q  <= 1'b0;
      end else if (issue_i) begin
         inh_q <= 1'b1;
         rd_q  <= issue_rd_i;
         wr_q  <= !issue_rd_i;
      end else if (last_blk) begin
         inh_q <= 1'b0;
         rd_q  <= 1'b0;
         wr_q  <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (cnt_wr_i) begin
         if (be_hi_i[0]) cnt_q[7:0]  <= wd_hi_i[7:0];
         if (be_hi_i[1]) cnt_q[15:8] <= wd_hi_i[15:8];
      end else if (blk_done_i && cnt_q != '0) begin
         cnt_q <= cnt_q - CNT_W'(1);
      end
   end

   assign inhibit_o = inh_q;
   assign rd_en_o   = rd_q;
   assign wr_en_o   = wr_q;
   assign blk_cnt_o = cnt_q;

   p_issue_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && !dat_rst_i) |=> (inhibit_o && (rd_en_o != wr_en_o)));
   p_en_needs_inh_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en_o || wr_en_o) |-> inhibit_o);
   p_last_blk_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (last_blk && !issue_i && !dat_rst_i) |=> (!inhibit_o && !rd_en_o && !wr_en_o));
   p_dat_rst_r10: assert property (@(posedge clk) disable iff (!rst_n)
      dat_rst_i |=> (!inhibit_o && !rd_en_o && !wr_en_o));
endmodule

// File: rtl/sdhx_data_port.sv
module sdhx_data_port
   import sdhx_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 512,
   parameter int unsigned BS_W      = 12
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_i,
   input  logic            rd_i,
   input  logic [3:0]      be_i,
   input  logic [31:0]     wdata_i,
   input  logic [BS_W-1:0] blk_size_i,
   input  logic            dat_rst_i,
   output logic [31:0]     rdata_o,
   output logic            blk_done_o,
   output logic            err_o
);
   localparam int unsigned LANES = 4;
   localparam int unsigned AW    = $clog2(BUF_BYTES);
   localparam int unsigned PTR_W = $clog2(BUF_BYTES + 1);
   localparam int unsigned CW    = ((PTR_W > BS_W) ? PTR_W : BS_W) + 1;

   if ((1 << AW) != BUF_BYTES || BUF_BYTES < 8) begin : g_bad_buf
      $error("BUF_BYTES must be a power of two of at least 8");
   end

   logic [7:0]       mem [BUF_BYTES];
   logic [PTR_W-1:0] ptr_q;
   logic             err_q;
   logic             acc;
   logic [2:0]       nbytes;
   logic [CW-1:0]    idx  [LANES];
   logic [AW-1:0]    lidx [LANES];
   logic [LANES-1:0] live, over;
   logic [2:0]       adv;

   assign acc    = wr_i || rd_i;
   assign nbytes = port_bytes(be_i);

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      logic in_acc, in_blk, in_buf;
      assign idx[g]   = CW'(ptr_q) + CW'(g);
      assign lidx[g]  = idx[g][AW-1:0];
      assign in_acc   = acc && (3'(g) < nbytes);
      assign in_blk   = idx[g] < CW'(blk_size_i);
      assign in_buf   = idx[g] < CW'(BUF_BYTES);
      assign live[g]  = in_acc && in_blk && in_buf;
      assign over[g]  = in_acc && in_blk && !in_buf;
      assign rdata_o[8*g +: 8] = live[g] ? mem[lidx[g]] : 8'h00;
   end

   assign adv        = 3'($countones(live));
   assign blk_done_o = (adv != 3'd0) &&
                       ((CW'(ptr_q) + CW'(adv)) == CW'(blk_size_i));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
         err_q <= 1'b0;
      end else if (dat_rst_i) begin
         ptr_q <= '0;
         err_q <= 1'b0;
      end else if (acc) begin
         ptr_q <= blk_done_o ? '0 : ptr_q + PTR_W'(adv);
         if (|over) err_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 0; i < LANES; i++) begin
         if (wr_i && live[i]) mem[lidx[i]] <= wdata_i[8*i +: 8];
      end
   end

   assign err_o = err_q;

   p_ptr_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ptr_q <= PTR_W'(BUF_BYTES));
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (err_o && !dat_rst_i) |=> err_o);
   p_wrap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (blk_done_o && acc && !dat_rst_i) |=> (ptr_q == '0));
endmodule

// File: rtl/sdhx_xfer_gate.sv
module sdhx_xfer_gate
   import sdhx_pkg::*;
#(
   parameter int unsigned BUF_BYTES = 512,
   parameter int unsigned BS_W      = 12
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        bus_wr,
   input  logic        bus_rd,
   input  logic [5:0]  bus_word,
   input  logic [3:0]  bus_be,
   input  logic [31:0] bus_wdata,
   output logic [31:0] bus_rdata,
   input  logic        cap_sdma,
   output logic [31:0] prs_state,
   output logic [15:0] xfer_mode,
   output logic [15:0] cmd_val,
   output logic        buf_rd_rdy,
   output logic        buf_wr_rdy,
   output logic        buf_err
);
   localparam int unsigned CNT_W = 16;

   logic            inhibit, rd_en, wr_en, issue, issue_rd, dat_rst, blk_done;
   logic            port_wr, port_rd;
   logic [BS_W-1:0] blk_size;
   logic [CNT_W-1:0] blk_cnt;
   logic [31:0]     port_rdata;

   assign dat_rst = bus_wr && (bus_word == W_RST) && bus_be[3] && bus_wdata[RST_DAT];
   assign port_wr = bus_wr && (bus_word == W_PORT) && wr_en;
   assign port_rd = bus_rd && !bus_wr && (bus_word == W_PORT) && rd_en;

   sdhx_mode_regs #(.BS_W(BS_W)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (bus_wr && (bus_word == W_XCMD)),
      .blk_wr_i   (bus_wr && (bus_word == W_BLK)),
      .wdata_i    (bus_wdata),
      .be_i       (bus_be),
      .inhibit_i  (inhibit),
      .cap_sdma_i (cap_sdma),
      .xfer_o     (xfer_mode),
      .cmd_o      (cmd_val),
      .blk_size_o (blk_size),
      .issue_o    (issue),
      .issue_rd_o (issue_rd)
   );

   sdhx_xfer_ctl #(.CNT_W(CNT_W)) u_ctl (
      .clk        (clk),
      .rst_n      (rst_n),
      .issue_i    (issue),
      .issue_rd_i (issue_rd),
      .dat_rst_i  (dat_rst),
      .blk_done_i (blk_done),
      .cnt_wr_i   (bus_wr && (bus_word == W_BLK)),
      .wd_hi_i    (bus_wdata[31:16]),
      .be_hi_i    (bus_be[3:2]),
      .inhibit_o  (inhibit),
      .rd_en_o    (rd_en),
      .wr_en_o    (wr_en),
      .blk_cnt_o  (blk_cnt)
   );

   sdhx_data_port #(.BUF_BYTES(BUF_BYTES), .BS_W(BS_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_i       (port_wr),
      .rd_i       (port_rd),
      .be_i       (bus_be),
      .wdata_i    (bus_wdata),
      .blk_size_i (blk_size),
      .dat_rst_i  (dat_rst),
      .rdata_o    (port_rdata),
      .blk_done_o (blk_done),
      .err_o      (buf_err)
   );

   always_comb begin
      prs_state           = '0;
      prs_state[PS_INH]   = inhibit;
      prs_state[PS_WR_EN] = wr_en;
      prs_state[PS_RD_EN] = rd_en;
   end

   always_comb begin
      case (bus_word)
         W_BLK:   bus_rdata = {blk_cnt, 16'(blk_size)};
         W_XCMD:  bus_rdata = {cmd_val, xfer_mode};
         W_PORT:  bus_rdata = port_rdata;
         W_PRS:   bus_rdata = prs_state;
         default: bus_rdata = '0;
      endcase
   end

   assign buf_rd_rdy = rd_en;
   assign buf_wr_rdy = wr_en;
endmodule

// File: tb/test_sdhx_xfer_gate.sv
module test_sdhx_xfer_gate;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0, bus_rd = 1'b0;
   logic [5:0]  bus_word = '0;
   logic [3:0]  bus_be = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        cap_sdma = 1'b0;
   logic [31:0] prs_state;
   logic [15:0] xfer_mode, cmd_val;
   logic        buf_rd_rdy, buf_wr_rdy, buf_err;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   always #4 clk = ~clk;

   sdhx_xfer_gate i_sdhx_xfer_gate (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_word(bus_word), .bus_be(bus_be), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cap_sdma(cap_sdma), .prs_state(prs_state),
      .xfer_mode(xfer_mode), .cmd_val(cmd_val), .buf_rd_rdy(buf_rd_rdy),
      .buf_wr_rdy(buf_wr_rdy), .buf_err(buf_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] w, input logic [31:0] d, input logic [3:0] be);
      @(negedge clk);
      bus_word = w; bus_wdata = d; bus_be = be; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic rd(input logic [5:0] w, input logic [3:0] be, output logic [31:0] d);
      @(negedge clk);
      bus_word = w; bus_be = be; bus_rd = 1'b1;
      #2 d = bus_rdata;
      @(negedge clk);
      bus_rd = 1'b0; bus_be = '0;
   endtask

   function automatic logic [15:0] mdl_xfer(input logic [15:0] old, input logic [31:0] d,
                                            input logic [3:0] be, input logic cap, input logic inh);
      logic [15:0] v;
      v = old;
      if (!inh) begin
         if (be[0]) v[7:0]  = d[7:0];
         if (be[1]) v[15:8] = d[15:8];
         if (be[0] && !cap) v[0] = 1'b0;
      end
      return v;
   endfunction

   function automatic logic [15:0] mdl_cmd(input logic [15:0] old, input logic [31:0] d,
                                           input logic [3:0] be);
      logic [15:0] v;
      v = old;
      if (be[2]) v[7:0]  = d[23:16];
      if (be[3]) v[15:8] = d[31:24];
      return v;
   endfunction

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [15:0] xm, cm;
      logic [31:0] d, r;
      logic [3:0]  be;
      r = $urandom(32'd17);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk("R1 xfer", {16'h0, xfer_mode}, 32'h0);
      chk("R1 cmd", {16'h0, cmd_val}, 32'h0);
      chk("R1 prs", prs_state, 32'h0);
      chk("R1 flags", {29'h0, buf_rd_rdy, buf_wr_rdy, buf_err}, 32'h0);
      rd(6'd1, 4'hF, r);
      chk("R1 blk word", r, 32'h0);

      // R3 R4 random mode writes, no data command issued
      xm = '0; cm = '0;
      for (int k = 0; k < 24; k++) begin
         d = $urandom();
         be = 4'($urandom());
         d[21] = 1'b0;
         cap_sdma = 1'($urandom());
         xm = mdl_xfer(xm, d, be, cap_sdma, 1'b0);
         cm = mdl_cmd(cm, d, be);
         wr(6'd3, d, be);
         chk("R3 R4 random mode write", {cmd_val, xfer_mode}, {cm, xm});
      end
      cap_sdma = 1'b0;
      wr(6'd3, 32'h0000_0011, 4'b0011);
      chk("R4 dma cleared without capability", {16'h0, xfer_mode}, 32'h0000_0010);
      cap_sdma = 1'b1;
      wr(6'd3, 32'h0000_0011, 4'b0011);
      chk("R4 dma kept with capability", {16'h0, xfer_mode}, 32'h0000_0011);

      // R11 block word readback
      wr(6'd1, {16'd2, 16'd8}, 4'hF);
      rd(6'd1, 4'hF, r);
      chk("R11 blk word", r, {16'd2, 16'd8});

      // R5 issue write-direction data command
      wr(6'd3, 32'h0020_0000, 4'hF);
      chk("R5 prs after write cmd", prs_state, 32'h0000_0402);
      chk("R5 wr rdy", {30'h0, buf_rd_rdy, buf_wr_rdy}, 32'h1);
      rd(6'd9, 4'hF, r);
      chk("R11 prs readback", r, 32'h0000_0402);

      // R2 transfer mode held while inhibited, command half updates
      wr(6'd3, 32'h1234_0013, 4'hF);
      chk("R2 xfer held", {16'h0, xfer_mode}, 32'h0);
      chk("R2 cmd updated", {16'h0, cmd_val}, 32'h0000_1234);
      chk("R5 no reissue while inhibited", prs_state, 32'h0000_0402);
      wr(6'd3, 32'h0000_FF00, 4'b0010);
      chk("R3 R2 byte write upper xfer held", {16'h0, xfer_mode}, 32'h0);
      rd(6'd3, 4'hF, r);
      chk("R11 word 3 readback", r, 32'h1234_0000);

      // R6 R7 first block of 8
      wr(6'd8, 32'h4433_2211, 4'b1111);
      wr(6'd8, 32'hFFFF_6655, 4'b0011);
      wr(6'd8, 32'hEEEE_EEEE, 4'b0101);
      wr(6'd8, 32'hFFFF_FF77, 4'b0001);
      rd(6'd1, 4'hF, r);
      chk("R6 count before block end", r, {16'd2, 16'd8});
      wr(6'd8, 32'hBBAA_9988, 4'b1111);
      rd(6'd1, 4'hF, r);
      chk("R7 block done count dec", r, {16'd1, 16'd8});
      chk("R7 still inhibited", prs_state, 32'h0000_0402);
      // second block ends the transfer
      wr(6'd8, 32'h0403_0201, 4'b1111);
      wr(6'd8, 32'h0807_0605, 4'b1111);
      chk("R8 prs cleared", prs_state, 32'h0);
      chk("R8 rdy cleared", {30'h0, buf_rd_rdy, buf_wr_rdy}, 32'h0);

      // R5 R6 R7 R8 read transfer
      wr(6'd1, {16'd1, 16'd8}, 4'hF);
      wr(6'd3, 32'h0020_0010, 4'hF);
      chk("R5 prs after read cmd", prs_state, 32'h0000_0802);
      chk("R5 rd rdy", {30'h0, buf_rd_rdy, buf_wr_rdy}, 32'h2);
      rd(6'd8, 4'b0001, r);
      chk("R6 1-byte read", r, 32'h0000_0001);
      rd(6'd8, 4'b0011, r);
      chk("R6 2-byte read", r, 32'h0000_0302);
      rd(6'd8, 4'b1111, r);
      chk("R6 4-byte read", r, 32'h0706_0504);
      rd(6'd8, 4'b1111, r);
      chk("R7 read past block end zero", r, 32'h0000_0008);
      chk("R8 read transfer ended", prs_state, 32'h0);
      rd(6'd8, 4'b1111, r);
      chk("R6 read without enable", r, 32'h0);

      // R9 bound on a 600-byte block
      wr(6'd1, {16'd1, 16'h0258}, 4'hF);
      wr(6'd3, 32'h0020_0000, 4'hF);
      for (int k = 0; k < 128; k++) wr(6'd8, 32'hA000_0000 + k, 4'hF);
      chk("R9 no error at bound", {31'h0, buf_err}, 32'h0);
      wr(6'd8, 32'hDEAD_BEEF, 4'hF);
      chk("R9 error set", {31'h0, buf_err}, 32'h1);
      chk("R9 transfer still open", prs_state, 32'h0000_0402);
      wr(6'd8, 32'hDEAD_BEEF, 4'hF);
      chk("R9 error sticky", {31'h0, buf_err}, 32'h1);

      // R10 data reset
      wr(6'd11, 32'h0400_0000, 4'b1000);
      chk("R10 prs cleared", prs_state, 32'h0);
      chk("R10 err cleared", {31'h0, buf_err}, 32'h0);
      wr(6'd3, 32'h0000_0011, 4'b0011);
      chk("R2 xfer stored when not inhibited", {16'h0, xfer_mode}, 32'h0000_0011);
      wr(6'd1, {16'd1, 16'd4}, 4'hF);
      wr(6'd3, 32'h0020_0010, 4'hF);
      rd(6'd8, 4'b1111, r);
      chk("R9 R10 byte 0 not wrapped, pointer reset", r, 32'hA000_0000);
      chk("R8 short read done", prs_state, 32'h0);

      finished = 1;
      summary();
      $finish;
   end
endmodule